// File: doc/BRIEF.md
# Two-Dimensional March Address Generator

This block produces the cell addresses for one march element over a memory array of 2^ROW_BITS rows by 2^COL_BITS columns. A test controller pulses `start` with a chosen traversal order and direction. It then raises `step` once for each memory operation group, and the block presents one new cell address per stepped cycle. `done` marks the final address of the pass, so the controller knows when to move on to the next march element.

Three traversal orders are available. In row-fast order each step moves to the next row. In column-fast order each step moves to the next column. In diagonal order each step moves along a wrapped diagonal, and the next diagonal starts once the current one is complete. Any order can run ascending or descending, and a descending pass is the exact reverse of the ascending pass in the same order. Data patterns, memory access and result comparison belong to other blocks.

Top module: `march_addr_gen`

## Requirements
- R1: After reset, `pass_valid` and `pass_done` are low.
- R2: A `start` with `go_down`=0 makes the block present row 0, column 0 with `pass_valid` high on the next cycle, whatever the order.
- R3: A `start` with `go_down`=1 makes the block present, on the next cycle, the address that the ascending pass of the same order visits last. In row-fast and column-fast order this address has every row and column bit set.
- R4: Each cycle with `step` high during a pass moves to the next address of the sequence. In a cycle with `step` low and `start` low, every output keeps its value.
- R5: Row-fast order, code 2'b00: the address at ascending position p has row = p mod 2^ROW_BITS and column = p div 2^ROW_BITS.
- R6: Column-fast order, code 2'b01, and the spare code 2'b11: the address at ascending position p has column = p mod 2^COL_BITS and row = p div 2^COL_BITS.
- R7: Diagonal order, code 2'b10: the address at ascending position p has k = p mod 2^ROW_BITS and d = p div 2^ROW_BITS. Its row is k and its column is (k + d) mod 2^COL_BITS.
- R8: A descending pass presents, at its i-th address, the address of ascending position N-1-i, where N = 2^(ROW_BITS+COL_BITS).
- R9: Each pass presents every cell exactly once, in all orders and both directions.
- R10: `lin_addr` equals the row index in its upper ROW_BITS bits, concatenated with the column index in its lower COL_BITS bits.
- R11: `pass_done` is high exactly while the last address of the pass is presented. A `step` in that cycle drops `pass_valid` and `pass_done` on the next cycle. A `step` while no pass is active has no effect.
- R12: Order and direction are sampled only at `start`. Changes on `sweep_mode` and `go_down` during a pass do not alter the sequence.
- R13: A `start` during a pass abandons that pass and loads the first address of the new pass on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new pass with the current order and direction |
| step | input | 1 | Advance to the next address |
| go_down | input | 1 | 1 selects a descending pass |
| sweep_mode | input | 2 | 00 row-fast, 01 column-fast, 10 diagonal, 11 column-fast |
| row_idx | output | ROW_BITS | Current row index |
| col_idx | output | COL_BITS | Current column index |
| lin_addr | output | ROW_BITS+COL_BITS | Row and column packed into one address |
| pass_valid | output | 1 | An address of an active pass is presented |
| pass_done | output | 1 | The presented address is the last of the pass |

## Verification
Every output responds exactly one clock edge after the `start` or `step` that caused it, because the position register is the only state on the path and the row and column mapping after it is combinational. The bench drives inputs just after a falling edge and samples just before the next falling edge, so each check sees the result of exactly one rising edge. Hold checks sample one further edge later with `step` low and compare against the previous address. The end of each pass is checked in the cycle after the final step, when `pass_valid` must already be low.

// File: rtl/march_addr_pkg.sv
// Package: shared encodings for the march address generator.
// Assumes: two bits select the traversal order; code 2'b11 is spare.
package march_addr_pkg;

    // Traversal order selected at the start of a pass.
    typedef enum logic [1:0] {
        SWEEP_ROW_FAST  = 2'b00,
        SWEEP_COL_FAST  = 2'b01,
        SWEEP_DIAG      = 2'b10,
        SWEEP_SPARE     = 2'b11
    } sweep_mode_e;

endpackage

// File: rtl/march_seq_ctrl.sv
// Module: march_seq_ctrl
// Holds the linear position of the pass and the order and direction
// captured at start. It counts up or down by one per step and flags
// the final position of the pass.
// Assumes: start has priority over step; a step while idle is ignored.
module march_seq_ctrl
    import march_addr_pkg::*;
#(
    parameter int SEQ_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                step,
    input  logic                go_down,
    input  logic [1:0]          sweep_mode,
    output logic [SEQ_BITS-1:0] seq_pos,
    output sweep_mode_e         mode_q,
    output logic                busy,
    output logic                at_last
);

    localparam logic [SEQ_BITS-1:0] POS_FIRST_UP = '0;
    localparam logic [SEQ_BITS-1:0] POS_FIRST_DN = '1;

    logic down_q;

    // Final position: the end value for the captured direction.
    always_comb begin
        at_last = down_q ? (seq_pos == POS_FIRST_UP) : (seq_pos == POS_FIRST_DN);
    end

    // Captures direction and order at start; advances the position on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_pos <= '0;
            down_q  <= 1'b0;
            mode_q  <= SWEEP_ROW_FAST;
            busy    <= 1'b0;
        end else if (start) begin
            seq_pos <= go_down ? POS_FIRST_DN : POS_FIRST_UP;
            down_q  <= go_down;
            mode_q  <= sweep_mode_e'(sweep_mode);
            busy    <= 1'b1;
        end else if (step && busy) begin
            if (at_last) begin
                busy <= 1'b0;
            end else if (down_q) begin
                seq_pos <= seq_pos - 1'b1;
            end else begin
                seq_pos <= seq_pos + 1'b1;
            end
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !start && !at_last && !down_q |=> seq_pos == $past(seq_pos) + 1'b1); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !start && !at_last && down_q |=> seq_pos == $past(seq_pos) - 1'b1); // R8

    AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> $stable(mode_q) && $stable(down_q)); // R12

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy && $stable(seq_pos)); // R11

endmodule

// File: rtl/march_addr_map.sv
// Module: march_addr_map
// Turns the linear pass position into a row and column index for the
// selected traversal order. The low bits of the position are always
// the fast-changing part; the order decides where they go.
// Assumes: purely combinational; the diagonal order covers any
// row/column width because each row sees every column offset once.
module march_addr_map
    import march_addr_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic [ROW_BITS+COL_BITS-1:0] seq_pos,
    input  sweep_mode_e                  mode_q,
    output logic [ROW_BITS-1:0]          row_idx,
    output logic [COL_BITS-1:0]          col_idx
);

    localparam int SEQ_BITS = ROW_BITS + COL_BITS;

    logic [ROW_BITS-1:0] rf_row;
    logic [COL_BITS-1:0] rf_col;
    logic [ROW_BITS-1:0] cf_row;
    logic [COL_BITS-1:0] cf_col;
    logic [COL_BITS-1:0] dg_k_ext;
    logic [COL_BITS-1:0] dg_col;

    // Row-fast split: low bits drive the row.
    always_comb begin
        rf_row = seq_pos[ROW_BITS-1:0];
        rf_col = seq_pos[SEQ_BITS-1:ROW_BITS];
    end

    // Column-fast split: low bits drive the column.
    always_comb begin
        cf_col = seq_pos[COL_BITS-1:0];
        cf_row = seq_pos[SEQ_BITS-1:COL_BITS];
    end

    // Diagonal: resize the in-diagonal index to the column width.
    generate
        if (ROW_BITS >= COL_BITS) begin : g_k_trunc
            always_comb dg_k_ext = seq_pos[COL_BITS-1:0];
        end else begin : g_k_ext
            always_comb dg_k_ext = {{(COL_BITS-ROW_BITS){1'b0}}, seq_pos[ROW_BITS-1:0]};
        end
    endgenerate

    // Diagonal column: in-diagonal index plus diagonal number, wrapped.
    always_comb begin
        dg_col = dg_k_ext + seq_pos[SEQ_BITS-1:ROW_BITS];
    end

    // Output select by captured order.
    always_comb begin
        unique case (mode_q)
            SWEEP_ROW_FAST: begin
                row_idx = rf_row;
                col_idx = rf_col;
            end
            SWEEP_DIAG: begin
                row_idx = seq_pos[ROW_BITS-1:0];
                col_idx = dg_col;
            end
            default: begin
                row_idx = cf_row;
                col_idx = cf_col;
            end
        endcase
    end

endmodule

// File: rtl/march_addr_gen.sv
// Module: march_addr_gen (top)
// Address generator for one march element over a 2^ROW_BITS by
// 2^COL_BITS array, in row-fast, column-fast or diagonal order,
// ascending or descending.
// Assumes: outputs follow start/step by one clock edge; order and
// direction are sampled only at start.
module march_addr_gen
    import march_addr_pkg::*;
#(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         step,
    input  logic                         go_down,
    input  logic [1:0]                   sweep_mode,
    output logic [ROW_BITS-1:0]          row_idx,
    output logic [COL_BITS-1:0]          col_idx,
    output logic [ROW_BITS+COL_BITS-1:0] lin_addr,
    output logic                         pass_valid,
    output logic                         pass_done
);

    localparam int SEQ_BITS = ROW_BITS + COL_BITS;

    logic [SEQ_BITS-1:0] seq_pos;
    sweep_mode_e         mode_q;
    logic                busy;
    logic                at_last;

    march_seq_ctrl #(.SEQ_BITS(SEQ_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (step),
        .go_down    (go_down),
        .sweep_mode (sweep_mode),
        .seq_pos    (seq_pos),
        .mode_q     (mode_q),
        .busy       (busy),
        .at_last    (at_last)
    );

    march_addr_map #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_map (
        .seq_pos (seq_pos),
        .mode_q  (mode_q),
        .row_idx (row_idx),
        .col_idx (col_idx)
    );

    // Packed address and pass flags.
    always_comb begin
        lin_addr   = {row_idx, col_idx};
        pass_valid = busy;
        pass_done  = busy && at_last;
    end

    AST_DONE_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> pass_valid); // R11

    AST_UP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        start && !go_down |=> pass_valid && row_idx == '0 && col_idx == '0); // R2

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !step |=> $stable(lin_addr) && $stable(pass_valid) && $stable(pass_done)); // R4

    AST_PASS_END: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done && step && !start |=> !pass_valid && !pass_done); // R11

endmodule

// File: tb/march_addr_gen_test.sv
module march_addr_gen_test;

    localparam int RB = 2;
    localparam int CB = 3;
    localparam int NR = 1 << RB;
    localparam int NC = 1 << CB;
    localparam int NCELL = NR * NC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            step = 1'b0;
    logic            go_down = 1'b0;
    logic [1:0]      sweep_mode = 2'b00;
    logic [RB-1:0]   row_idx;
    logic [CB-1:0]   col_idx;
    logic [RB+CB-1:0] lin_addr;
    logic            pass_valid;
    logic            pass_done;

    int checks = 0;
    int errors = 0;
    bit seen [NCELL];

    march_addr_gen #(.ROW_BITS(RB), .COL_BITS(CB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .go_down(go_down), .sweep_mode(sweep_mode),
        .row_idx(row_idx), .col_idx(col_idx), .lin_addr(lin_addr),
        .pass_valid(pass_valid), .pass_done(pass_done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected row and column at ascending position p.
    function automatic void exp_rc(input int m, input int p, output int r, output int c);
        int k;
        int d;
        case (m)
            0: begin r = p % NR; c = p / NR; end
            2: begin k = p % NR; d = p / NR; r = k; c = (k + d) % NC; end
            default: begin c = p % NC; r = p / NC; end
        endcase
    endfunction

    // One whole pass with optional idle gaps and input disturbance.
    task automatic run_pass(input int m, input bit dn, input bit gaps);
        int er;
        int ec;
        string rq;
        rq = (m == 0) ? "R5" : (m == 2) ? "R7" : "R6";
        for (int j = 0; j < NCELL; j++) seen[j] = 1'b0;
        sweep_mode = m[1:0];
        go_down = dn;
        start = 1'b1;
        step = 1'b0;
        tick();
        start = 1'b0;
        // R12: disturb order and direction inputs during the pass
        sweep_mode = ~m[1:0];
        go_down = ~dn;
        for (int i = 0; i < NCELL; i++) begin
            int p;
            p = dn ? (NCELL - 1 - i) : i;
            exp_rc(m, p, er, ec);
            check(pass_valid == 1'b1, "R4 valid in pass", int'(pass_valid), 1);
            check(int'(row_idx) == er, dn ? "R8 row" : {rq, " row"}, int'(row_idx), er);
            check(int'(col_idx) == ec, dn ? "R8 col" : {rq, " col"}, int'(col_idx), ec);
            check(int'(lin_addr) == er * NC + ec, "R10 packed", int'(lin_addr), er * NC + ec);
            check(pass_done == (i == NCELL - 1), "R11 done", int'(pass_done), int'(i == NCELL - 1));
            check(!seen[er * NC + ec], "R9 revisit", er * NC + ec, -1);
            seen[er * NC + ec] = 1'b1;
            if (gaps && (i % 3 == 1)) begin
                step = 1'b0;
                tick();
                check(int'(lin_addr) == er * NC + ec, "R4 hold", int'(lin_addr), er * NC + ec);
                check(pass_valid == 1'b1, "R4 hold valid", int'(pass_valid), 1);
            end
            step = 1'b1;
            tick();
        end
        check(pass_valid == 1'b0, "R11 end valid", int'(pass_valid), 0);
        check(pass_done == 1'b0, "R11 end done", int'(pass_done), 0);
        // R11: step while idle has no effect
        tick();
        check(pass_valid == 1'b0, "R11 idle step", int'(pass_valid), 0);
        step = 1'b0;
        for (int j = 0; j < NCELL; j++)
            check(seen[j], "R9 coverage", int'(seen[j]), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int er;
        int ec;
        @(negedge clk);
        tick();
        check(pass_valid == 1'b0, "R1 valid", int'(pass_valid), 0);
        check(pass_done == 1'b0, "R1 done", int'(pass_done), 0);
        rst_n = 1'b1;
        tick();

        // R2 and R3: first address for every order and direction
        for (int m = 0; m < 4; m++) begin
            for (int dn = 0; dn < 2; dn++) begin
                sweep_mode = m[1:0];
                go_down = dn[0];
                start = 1'b1;
                tick();
                start = 1'b0;
                exp_rc(m, dn ? NCELL - 1 : 0, er, ec);
                check(int'(lin_addr) == er * NC + ec, dn ? "R3 first" : "R2 first",
                      int'(lin_addr), er * NC + ec);
                check(pass_valid == 1'b1, "R2 valid", int'(pass_valid), 1);
                if (dn != 0 && m != 2)
                    check(int'(lin_addr) == NCELL - 1, "R3 all ones", int'(lin_addr), NCELL - 1);
            end
        end

        // Full passes: R5 R6 R7 R8 R9, spare code behaves as column-fast
        for (int m = 0; m < 4; m++) begin
            run_pass(m, 1'b0, m[0]);
            run_pass(m, 1'b1, ~m[0]);
        end

        // R13: restart in mid-pass
        sweep_mode = 2'b01;
        go_down = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        step = 1'b1;
        repeat (5) tick();
        check(int'(lin_addr) == 5, "R13 mid pass", int'(lin_addr), 5);
        step = 1'b0;
        go_down = 1'b1;
        sweep_mode = 2'b00;
        start = 1'b1;
        tick();
        start = 1'b0;
        check(int'(lin_addr) == NCELL - 1, "R13 restart", int'(lin_addr), NCELL - 1);
        check(pass_done == 1'b0, "R13 done low", int'(pass_done), 0);
        step = 1'b1;
        tick();
        step = 1'b0;
        exp_rc(0, NCELL - 2, er, ec);
        check(int'(lin_addr) == er * NC + ec, "R13 next", int'(lin_addr), er * NC + ec);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule